// File: doc/BRIEF.md
# Two-Point Black-Level Calibration Sequencer

This block is the digital controller of a cathode black-current regulation loop in a CRT display processor. Once per field it opens a short leakage window on a chosen video line. It then inserts a test level and samples three comparator results, one per colour gun. Each result says whether the measured cathode current is above its reference. The analog current sensing, the DACs and the video path sit outside the block. They see only the window strobes and the correction codes the block produces.

The test level alternates between fields. The low-current field steers the per-gun black-level offset codes and the high-current field steers the per-gun gain codes. When the loop is dithering around its targets on every code for several consecutive field pairs, it is declared settled. The loop-fault flag then drops, and the first such drop releases the power-up blanking. A one-point mode keeps the gain codes frozen. Two signed trims move the red and green black levels relative to the loop result. A two-bit status reports where the lowest black level sits against a window.

Top module: `blk_cal_seq`

## Requirements
- R1: After reset every offset and gain code holds midscale 2^(LVL_W-1), `fault` and `blank` are 1, `test_hi` is 0 and both window strobes are 0.
- R2: On the MEAS_LINE-th `line_start` pulse after a `field_start` pulse, `leak_win` is high for WIN cycles starting the next cycle. It is followed at once by WIN cycles of `test_ins`. The two are never high together, and this happens once per field.
- R3: `test_hi` is 0 for the first measured field after reset and inverts after every completed measurement (leakage fields included), so low-current and high-current fields alternate.
- R4: In a low field (`test_hi`=0) with no leakage fault, each offset code steps by one: down when its `cmp_above` bit (bit 0 red, bit 1 green, bit 2 blue) is 1, up when it is 0. A code does not move past 0 or 2^LVL_W-1.
- R5: In a high field in two-point mode (`one_point`=0), the gain codes step by the same rule and limits as in R4, using the same bit order.
- R6: With `one_point`=1 the gain codes never change.
- R7: When `leak_bad` is 1 on the last leakage-window cycle, no code moves in that field, `fault` is set and the settle count restarts.
- R8: A step that a code cannot take because it is already at a limit sets `fault` and restarts the settle count.
- R9: A field pair (low field, then high field) counts as steady when every code it stepped moved opposite to its own previous move. Gain codes are left out in one-point mode. `fault` clears at the end of the SETTLE-th consecutive steady pair.
- R10: `blank` is 1 from reset, drops in the same cycle that `fault` first falls, and never rises again.
- R11: With m the smallest of the three offset codes, `in_win`=1 when WIN_LO ≤ m ≤ WIN_HI, `above_win`=1 when m > WIN_HI, and both are 0 when m < WIN_LO.
- R12: `blk_r` = clamp(`off_r` + `trim_r`, 0, 2^LVL_W-1) and `blk_g` likewise with `trim_g`, both trims two's complement. `blk_b` equals `off_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_start | input | 1 | Single-cycle strobe at each field start |
| line_start | input | 1 | Single-cycle strobe at each line start |
| one_point | input | 1 | 1 freezes the gain codes |
| leak_bad | input | 1 | Leakage comparator, 1 = leakage out of range |
| cmp_above | input | 3 | Per-gun comparator, 1 = current above reference (0 red, 1 green, 2 blue) |
| trim_r | input | TRIM_W | Signed red black-level trim |
| trim_g | input | TRIM_W | Signed green black-level trim |
| leak_win | output | 1 | Leakage measurement window |
| test_ins | output | 1 | Test-level insertion window |
| test_hi | output | 1 | 1 = high-current test level this field |
| blank | output | 1 | RGB blanking request |
| fault | output | 1 | Loop-fault flag |
| in_win | output | 1 | Lowest black level inside window |
| above_win | output | 1 | Lowest black level above window |
| off_r | output | LVL_W | Red offset code |
| off_g | output | LVL_W | Green offset code |
| off_b | output | LVL_W | Blue offset code |
| gain_r | output | LVL_W | Red gain code |
| gain_g | output | LVL_W | Green gain code |
| gain_b | output | LVL_W | Blue gain code |
| blk_r | output | LVL_W | Red black level after trim |
| blk_g | output | LVL_W | Green black level after trim |
| blk_b | output | LVL_W | Blue black level |

## Verification
The bench builds the block with 5-bit codes, 3-bit trims, 2-cycle windows, measurement on line 2 and a status window of 12 to 20. With these values a code can walk from midscale to either rail within a few dozen fields, so saturation faults and all three status outcomes show up in a short run. The narrow trims allow every red and green trim pair to be swept at midrange and at both rails, clamping included. A plant model in the bench drives the comparators from targets. Convergence, dithering, settle counting, leakage faults and one-point mode are then checked field by field against an arithmetic model of the codes.

// File: rtl/blk_cal_seq.sv
module blk_cal_seq #(
  parameter int LVL_W     = 7,
  parameter int TRIM_W    = 4,
  parameter int WIN       = 16,
  parameter int MEAS_LINE = 20,
  parameter int LINE_W    = 10,
  parameter int SETTLE    = 4,
  parameter int WIN_LO    = 48,
  parameter int WIN_HI    = 80
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     field_start,
  input  logic                     line_start,
  input  logic                     one_point,
  input  logic                     leak_bad,
  input  logic [2:0]               cmp_above,
  input  logic signed [TRIM_W-1:0] trim_r,
  input  logic signed [TRIM_W-1:0] trim_g,
  output logic                     leak_win,
  output logic                     test_ins,
  output logic                     test_hi,
  output logic                     blank,
  output logic                     fault,
  output logic                     in_win,
  output logic                     above_win,
  output logic [LVL_W-1:0]         off_r,
  output logic [LVL_W-1:0]         off_g,
  output logic [LVL_W-1:0]         off_b,
  output logic [LVL_W-1:0]         gain_r,
  output logic [LVL_W-1:0]         gain_g,
  output logic [LVL_W-1:0]         gain_b,
  output logic [LVL_W-1:0]         blk_r,
  output logic [LVL_W-1:0]         blk_g,
  output logic [LVL_W-1:0]         blk_b
);
  localparam int PW  = $clog2(WIN) + 1;
  localparam int SCW = $clog2(SETTLE + 1);
  localparam int SW  = LVL_W + 2;
  localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] MID = LVL_W'(1) << (LVL_W - 1);
  localparam logic [LINE_W-1:0] LMAX = {LINE_W{1'b1}};

  typedef enum logic [1:0] {IDLE, LEAK, TEST} phase_t;

  phase_t           ph;
  logic [PW-1:0]    pcnt;
  logic [LINE_W-1:0] lcnt;
  logic [SCW-1:0]   scnt;
  logic             leak_q, rev_lo_q;
  logic [LVL_W-1:0] off  [3];
  logic [LVL_W-1:0] gain [3];
  logic [5:0]       dir, dv;

  wire last  = (pcnt == PW'(WIN - 1));
  wire start = line_start & ~field_start & (ph == IDLE) & (lcnt == LINE_W'(MEAS_LINE - 1));
  wire upd   = (ph == TEST) & last;
  wire [2:0] up = ~cmp_above;

  logic [2:0] sat_o, sat_g, rev_o, rev_g;
  always_comb begin
    for (int i = 0; i < 3; i++) begin
      sat_o[i] = up[i] ? (off[i] == TOP)  : (off[i] == '0);
      sat_g[i] = up[i] ? (gain[i] == TOP) : (gain[i] == '0);
      rev_o[i] = dv[i]   & (dir[i]   != up[i]) & ~sat_o[i];
      rev_g[i] = dv[3+i] & (dir[3+i] != up[i]) & ~sat_g[i];
    end
  end

  wire gstep   = test_hi & ~one_point;
  wire any_sat = (~test_hi & |sat_o) | (gstep & |sat_g);
  wire pair_ok = rev_lo_q & (one_point | &rev_g);
  wire [SCW-1:0] scnt_nx = (scnt == SCW'(SETTLE)) ? scnt : scnt + 1'b1;
  wire fault_clr = upd & ~leak_q & test_hi & ~any_sat & pair_ok & (scnt_nx == SCW'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= IDLE;
      pcnt <= '0;
      lcnt <= '0;
      leak_q <= 1'b0;
    end else begin
      if (field_start) lcnt <= '0;
      else if (line_start && lcnt != LMAX) lcnt <= lcnt + 1'b1;
      case (ph)
        IDLE: if (start) begin ph <= LEAK; pcnt <= '0; end
        LEAK: if (last) begin ph <= TEST; pcnt <= '0; leak_q <= leak_bad; end
              else pcnt <= pcnt + 1'b1;
        default: if (last) ph <= IDLE; else pcnt <= pcnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        off[i]  <= MID;
        gain[i] <= MID;
      end
      dir <= '0;
      dv <= '0;
      test_hi <= 1'b0;
      fault <= 1'b1;
      blank <= 1'b1;
      scnt <= '0;
      rev_lo_q <= 1'b0;
    end else if (upd) begin
      test_hi <= ~test_hi;
      if (leak_q) begin
        fault <= 1'b1;
        scnt <= '0;
        rev_lo_q <= 1'b0;
      end else begin
        for (int i = 0; i < 3; i++) begin
          if (!test_hi && !sat_o[i]) begin
            off[i] <= up[i] ? off[i] + 1'b1 : off[i] - 1'b1;
            dir[i] <= up[i];
            dv[i] <= 1'b1;
          end
          if (gstep && !sat_g[i]) begin
            gain[i] <= up[i] ? gain[i] + 1'b1 : gain[i] - 1'b1;
            dir[3+i] <= up[i];
            dv[3+i] <= 1'b1;
          end
        end
        if (any_sat) begin
          fault <= 1'b1;
          scnt <= '0;
          rev_lo_q <= 1'b0;
        end else if (!test_hi) begin
          rev_lo_q <= &rev_o;
        end else if (pair_ok) begin
          scnt <= scnt_nx;
          if (fault_clr) begin
            fault <= 1'b0;
            blank <= 1'b0;
          end
        end else begin
          scnt <= '0;
        end
      end
    end
  end

  assign leak_win = (ph == LEAK);
  assign test_ins = (ph == TEST);
  assign off_r  = off[0];
  assign off_g  = off[1];
  assign off_b  = off[2];
  assign gain_r = gain[0];
  assign gain_g = gain[1];
  assign gain_b = gain[2];

  wire [LVL_W-1:0] m01 = (off[0] < off[1]) ? off[0] : off[1];
  wire [LVL_W-1:0] mn  = (m01 < off[2]) ? m01 : off[2];
  assign in_win    = (mn >= LVL_W'(WIN_LO)) && (mn <= LVL_W'(WIN_HI));
  assign above_win = (mn > LVL_W'(WIN_HI));

  wire signed [SW-1:0] sr = $signed({2'b00, off[0]}) + SW'(trim_r);
  wire signed [SW-1:0] sg = $signed({2'b00, off[1]}) + SW'(trim_g);
  wire signed [SW-1:0] stop = $signed({2'b00, TOP});
  assign blk_r = (sr < 0) ? '0 : (sr > stop) ? TOP : sr[LVL_W-1:0];
  assign blk_g = (sg < 0) ? '0 : (sg > stop) ? TOP : sg[LVL_W-1:0];
  assign blk_b = off[2];
endmodule

// File: rtl/blk_cal_seq_chk.sv
module blk_cal_seq_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             one_point,
  input logic             leak_win,
  input logic             test_ins,
  input logic             blank,
  input logic             fault,
  input logic             in_win,
  input logic             above_win,
  input logic [LVL_W-1:0] off_r,
  input logic [LVL_W-1:0] gain_r,
  input logic [LVL_W-1:0] gain_g,
  input logic [LVL_W-1:0] gain_b
);
  assert_win_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(leak_win && test_ins));
  assert_leak_then_test_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(leak_win) |-> test_ins);
  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (off_r != $past(off_r)) |-> (off_r == $past(off_r) + LVL_W'(1) || off_r == $past(off_r) - LVL_W'(1)));
  assert_gain_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(one_point) |-> ($stable(gain_r) && $stable(gain_g) && $stable(gain_b)));
  assert_blank_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |=> !blank);
  assert_blank_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank) |-> $fell(fault));
  assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_win && above_win));
endmodule

bind blk_cal_seq blk_cal_seq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .one_point(one_point), .leak_win(leak_win),
  .test_ins(test_ins), .blank(blank), .fault(fault), .in_win(in_win),
  .above_win(above_win), .off_r(off_r), .gain_r(gain_r), .gain_g(gain_g),
  .gain_b(gain_b)
);

// File: tb/sim_blk_cal_seq.sv
module sim_blk_cal_seq;
  localparam int LW = 5, TW = 3, WN = 2, ML = 2, ST = 4, WLO = 12, WHI = 20;
  localparam int MX = (1 << LW) - 1;

  logic clk = 0, rst_n = 0, field_start = 0, line_start = 0, one_point = 0, leak_bad = 0;
  logic [2:0] cmp_above = '0;
  logic signed [TW-1:0] trim_r = '0, trim_g = '0;
  logic leak_win, test_ins, test_hi, blank, fault, in_win, above_win;
  logic [LW-1:0] off_r, off_g, off_b, gain_r, gain_g, gain_b, blk_r, blk_g, blk_b;

  blk_cal_seq #(.LVL_W(LW), .TRIM_W(TW), .WIN(WN), .MEAS_LINE(ML), .LINE_W(4),
                .SETTLE(ST), .WIN_LO(WLO), .WIN_HI(WHI)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int lk_n, ts_n;
  bit order_bad;

  int m_off[3], m_gain[3], to[3], tg[3];
  bit m_dir[6], m_dv[6];
  bit m_hi, m_fault, m_blank, m_revlo;
  int m_scnt;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (leak_win) begin lk_n++; if (ts_n != 0) order_bad = 1; end
    if (test_ins) ts_n++;
    if (leak_win && test_ins) order_bad = 1;
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  function automatic int expstat();
    int mn = m_off[0];
    for (int i = 1; i < 3; i++) if (m_off[i] < mn) mn = m_off[i];
    return (mn > WHI) ? 2 : (mn >= WLO) ? 1 : 0;
  endfunction

  task automatic check_state(input string tag);
    chk({"R4 off_r ", tag}, off_r, m_off[0]);
    chk({"R4 off_g ", tag}, off_g, m_off[1]);
    chk({"R4 off_b ", tag}, off_b, m_off[2]);
    chk({"R5 gain_r ", tag}, gain_r, m_gain[0]);
    chk({"R5 gain_g ", tag}, gain_g, m_gain[1]);
    chk({"R5 gain_b ", tag}, gain_b, m_gain[2]);
    chk({"R9 fault ", tag}, fault, m_fault);
    chk({"R10 blank ", tag}, blank, m_blank);
    chk({"R11 status ", tag}, {above_win, in_win}, expstat());
  endtask

  task automatic do_field(input bit lk, input bit op);
    bit [2:0] c;
    bit anysat, allrev, u, s, rv;
    int v, k;
    for (int i = 0; i < 3; i++) c[i] = m_hi ? (m_gain[i] > tg[i]) : (m_off[i] > to[i]);
    chk("R3 test_hi", test_hi, m_hi);
    cmp_above = c; leak_bad = lk; one_point = op;
    lk_n = 0; ts_n = 0; order_bad = 0;
    field_start = 1; @(negedge clk); field_start = 0;
    repeat (2) @(negedge clk);
    for (int l = 0; l < ML; l++) begin
      line_start = 1; @(negedge clk); line_start = 0;
      repeat (10) @(negedge clk);
    end
    chk("R2 leak cycles", lk_n, WN);
    chk("R2 test cycles", ts_n, WN);
    chk("R2 order", order_bad, 0);
    anysat = 0; allrev = 1;
    if (lk) begin
      m_fault = 1; m_scnt = 0; m_revlo = 0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        u = !c[i];
        if (!m_hi || !op) begin
          k = m_hi ? 3 + i : i;
          v = m_hi ? m_gain[i] : m_off[i];
          s = u ? (v == MX) : (v == 0);
          rv = 0;
          if (!s) begin
            rv = m_dv[k] && (m_dir[k] != u);
            v = u ? v + 1 : v - 1;
            m_dir[k] = u; m_dv[k] = 1;
            if (m_hi) m_gain[i] = v; else m_off[i] = v;
          end
          anysat |= s; allrev &= rv;
        end
      end
      if (anysat) begin
        m_fault = 1; m_scnt = 0; m_revlo = 0;
      end else if (!m_hi) m_revlo = allrev;
      else if (m_revlo && (op || allrev)) begin
        if (m_scnt < ST) m_scnt++;
        if (m_scnt >= ST) begin
          if (m_fault) m_blank = 0;
          m_fault = 0;
        end
      end else m_scnt = 0;
    end
    m_hi = !m_hi;
    check_state(lk ? "leak" : (op ? "1pt" : "2pt"));
  endtask

  task automatic trim_sweep(input string tag);
    for (int a = -4; a < 4; a++)
      for (int b = -4; b < 4; b++) begin
        int er, eg;
        trim_r = TW'(a); trim_g = TW'(b);
        #1;
        er = m_off[0] + a; er = er < 0 ? 0 : er > MX ? MX : er;
        eg = m_off[1] + b; eg = eg < 0 ? 0 : eg > MX ? MX : eg;
        chk({"R12 blk_r ", tag}, blk_r, er);
        chk({"R12 blk_g ", tag}, blk_g, eg);
      end
    trim_r = '0; trim_g = '0;
    #1;
    chk({"R12 blk_b ", tag}, blk_b, m_off[2]);
  endtask

  initial begin
    int g0[3];
    for (int i = 0; i < 3; i++) begin m_off[i] = 1 << (LW - 1); m_gain[i] = 1 << (LW - 1); end
    for (int i = 0; i < 6; i++) begin m_dir[i] = 0; m_dv[i] = 0; end
    m_hi = 0; m_fault = 1; m_blank = 1; m_revlo = 0; m_scnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_state("R1 reset");
    chk("R1 test_hi", test_hi, 0);
    chk("R1 windows", {leak_win, test_ins}, 0);

    to = '{18, 13, 16}; tg = '{20, 12, 16};
    for (int f = 0; f < 24; f++) do_field(0, 0);
    chk("R9 settled", fault, 0);
    chk("R10 released", blank, 0);
    trim_sweep("mid");

    g0 = m_gain;
    tg = '{0, 0, 0};
    for (int f = 0; f < 6; f++) do_field(0, 1);
    chk("R6 gain_r held", gain_r, g0[0]);
    chk("R6 gain_b held", gain_b, g0[2]);

    do_field(1, 0);
    chk("R7 leak fault", fault, 1);
    chk("R10 no reblank", blank, 0);
    tg = '{20, 12, 16};
    for (int f = 0; f < 12; f++) do_field(0, 0);
    chk("R9 resettled", fault, 0);

    to = '{99, 99, 99};
    for (int f = 0; f < 40; f++) do_field(0, 1);
    chk("R8 top fault", fault, 1);
    chk("R11 above", above_win, 1);
    chk("R4 off_r top", off_r, MX);
    trim_sweep("top");

    to = '{-1, -1, -1};
    for (int f = 0; f < 70; f++) do_field(0, 1);
    chk("R8 bottom fault", fault, 1);
    chk("R11 below", {above_win, in_win}, 0);
    chk("R4 off_g bottom", off_g, 0);
    trim_sweep("bottom");

    done = 1;
    summary();
    $finish;
  end
endmodule